// File: doc/BRIEF.md
# Permission-set sequencer

This block performs one privileged change of a physical page's 16-bit permission entry as a fixed hardware sequence that software cannot bypass. A request carries a virtual page number, the requested entry and the level of the requester (user, OS or hypervisor). The block first looks the page up through a TLB lookup port. It then reads the current entry from a protected table in memory at a base-indexed address. Next it asks an external rule matcher whether the transition from the current entry to the new one is allowed for that requester.

When a rule matches, the block carries out the action the rule demands, which is a zero-fill of the whole 4 KB page. Only after that does it write the new entry, first to the protected table and then to the TLB copy, and it signals completion. When no rule matches, nothing is written and a violation is reported. When the TLB lookup misses, a separate fault is reported.

The table base is a 64-bit register that can be loaded once after reset, during boot, and is locked from then on.

Top module: `perm_set_seq`

## Requirements
- R1: After reset `busy`, `done`, `violation`, `tlb_fault` and all bus requests are low. A request is accepted only while `busy` is low. `busy` is high from the edge after acceptance until the edge that raises `done`, `violation` or `tlb_fault`, and is low in that cycle. A `req_valid` seen while busy has no effect.
- R2: The accepted virtual page is presented on `tlb_vpage` with `tlb_req`. A response with `tlb_rsp_hit` low produces a one-cycle `tlb_fault` pulse, with no memory read, no rule query and no write, and the block returns to idle.
- R3: The current entry is fetched by a read (`mem_we` low) at address base + 2 × PPN, where PPN is the translated page number.
- R4: The first `boot_base_we` after reset loads `boot_base_val` into the base register. Every later `boot_base_we` is ignored until the next reset.
- R5: The rule query presents the requester level on `rule_level`, the entry read from memory (`mem_rdata`) on `rule_cur`, and the requested entry on `rule_new`.
- R6: A rule response with `rule_hit` low produces a one-cycle `violation` pulse, and no memory write and no TLB update take place.
- R7: A hit with `rule_wipe` high issues 4096 / (DATA_W/8) wide writes (`mem_wide` high) of zero data, at ascending addresses from PPN × 4096 in steps of DATA_W/8. All of them complete before the entry write.
- R8: After the action, a narrow write (`mem_wide` low) puts the new entry at the address of R3. A TLB update with the request's virtual page and the same entry follows, and then a one-cycle `done` pulse.
- R9: The entry layout is bits [2:0] user read/write/execute, [5:3] OS, [8:6] hypervisor, [9] page-table page, [10] shared, and [15:11] reserved. The reserved bits are cleared on the rule query, the memory write and the TLB update, whatever the request carried.
- R10: With every responder answering in the cycle it is asked, the outcome flag rises on the following edge counted from the acceptance edge: `tlb_fault` 1, `violation` 4, `done` 6, and `done` 6 + 4096/(DATA_W/8) with a wipe.
- R11: A memory request that is not accepted (`mem_ready` low) is held with the same address into the next cycle. Stalls only delay the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_base_we | input | 1 | Load strobe for the table base (first one only) |
| boot_base_val | input | 64 | Table base value |
| req_valid | input | 1 | New permission-change request |
| req_vpage | input | VPN_W | Virtual page number of the request |
| req_entry | input | 16 | Requested permission entry |
| req_level | input | 2 | Requester level |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse: change committed |
| violation | output | 1 | One-cycle pulse: no rule allows the change |
| tlb_fault | output | 1 | One-cycle pulse: translation missed |
| tlb_req | output | 1 | TLB lookup request |
| tlb_vpage | output | VPN_W | Page to translate |
| tlb_rsp_valid | input | 1 | Lookup response valid |
| tlb_rsp_hit | input | 1 | Lookup hit |
| tlb_rsp_ppn | input | PPN_W | Translated physical page number |
| tlb_wr_valid | output | 1 | TLB entry update request |
| tlb_wr_vpage | output | VPN_W | Page whose TLB copy is updated |
| tlb_wr_entry | output | 16 | New entry for the TLB copy |
| tlb_wr_ready | input | 1 | TLB update accepted |
| rule_req | output | 1 | Rule query request |
| rule_level | output | 2 | Requester level for the query |
| rule_cur | output | 16 | Current entry for the query |
| rule_new | output | 16 | Requested entry for the query |
| rule_rsp_valid | input | 1 | Rule response valid |
| rule_hit | input | 1 | A rule allows the transition |
| rule_wipe | input | 1 | The matching rule demands a page wipe |
| mem_valid | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_wide | output | 1 | Write is a full data word of the page wipe |
| mem_addr | output | 64 | Byte address |
| mem_wdata | output | DATA_W | Write data |
| mem_ready | input | 1 | Memory request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read entry data |

## Verification
Every responder in the bench answers in the cycle it sees a request, unless stalling is switched on for that run. The outcome flags therefore have fixed due edges counted from the acceptance edge: the fault on edge 1, the violation on edge 4, completion on edge 6, and completion on edge 6 plus one edge per wipe word. The bench drives and samples a quarter period after each rising edge and counts edges from acceptance. In runs without stalls it compares that count with these figures. In stalled runs it checks the same traffic and ordering, but not the timing.

// File: rtl/perm_set_seq.sv
module perm_set_seq #(
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  parameter int DATA_W = 32,
  parameter int PAGE_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_base_we,
  input  logic [63:0]       boot_base_val,
  input  logic              req_valid,
  input  logic [VPN_W-1:0]  req_vpage,
  input  logic [15:0]       req_entry,
  input  logic [1:0]        req_level,
  output logic              busy,
  output logic              done,
  output logic              violation,
  output logic              tlb_fault,
  output logic              tlb_req,
  output logic [VPN_W-1:0]  tlb_vpage,
  input  logic              tlb_rsp_valid,
  input  logic              tlb_rsp_hit,
  input  logic [PPN_W-1:0]  tlb_rsp_ppn,
  output logic              tlb_wr_valid,
  output logic [VPN_W-1:0]  tlb_wr_vpage,
  output logic [15:0]       tlb_wr_entry,
  input  logic              tlb_wr_ready,
  output logic              rule_req,
  output logic [1:0]        rule_level,
  output logic [15:0]       rule_cur,
  output logic [15:0]       rule_new,
  input  logic              rule_rsp_valid,
  input  logic              rule_hit,
  input  logic              rule_wipe,
  output logic              mem_valid,
  output logic              mem_we,
  output logic              mem_wide,
  output logic [63:0]       mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic              mem_rvalid,
  input  logic [15:0]       mem_rdata
);
  localparam int BYTES = DATA_W / 8;
  localparam int BSH = $clog2(BYTES);
  localparam int WIPE_N = (1 << PAGE_SHIFT) / BYTES;
  localparam int CNT_W = $clog2(WIPE_N);
  localparam logic [15:0] KEEP = 16'h07FF;

  typedef enum logic [2:0] {
    S_IDLE, S_XLATE, S_RD, S_RDW, S_MATCH, S_WIPE, S_WRM, S_WRT
  } st_t;

  st_t              st;
  logic [63:0]      base_q;
  logic             base_lock;
  logic [VPN_W-1:0] vpn_q;
  logic [PPN_W-1:0] ppn_q;
  logic [15:0]      new_q, cur_q;
  logic [1:0]       lvl_q;
  logic [CNT_W-1:0] widx;

  logic [63:0] ppn_ext, ent_addr, wipe_addr;
  logic        wipe_last;

  assign ppn_ext   = {{(64-PPN_W){1'b0}}, ppn_q};
  assign ent_addr  = base_q + (ppn_ext << 1);
  assign wipe_addr = (ppn_ext << PAGE_SHIFT) + ({{(64-CNT_W){1'b0}}, widx} << BSH);
  assign wipe_last = (widx == CNT_W'(WIPE_N - 1));

  assign busy         = (st != S_IDLE);
  assign tlb_req      = (st == S_XLATE);
  assign tlb_vpage    = vpn_q;
  assign rule_req     = (st == S_MATCH);
  assign rule_level   = lvl_q;
  assign rule_cur     = cur_q;
  assign rule_new     = new_q;
  assign mem_valid    = (st == S_RD) || (st == S_WIPE) || (st == S_WRM);
  assign mem_we       = (st == S_WIPE) || (st == S_WRM);
  assign mem_wide     = (st == S_WIPE);
  assign mem_addr     = (st == S_WIPE) ? wipe_addr : ent_addr;
  assign mem_wdata    = (st == S_WRM) ? {{(DATA_W-16){1'b0}}, new_q} : '0;
  assign tlb_wr_valid = (st == S_WRT);
  assign tlb_wr_vpage = vpn_q;
  assign tlb_wr_entry = new_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      base_q    <= '0;
      base_lock <= 1'b0;
      vpn_q     <= '0;
      ppn_q     <= '0;
      new_q     <= '0;
      cur_q     <= '0;
      lvl_q     <= '0;
      widx      <= '0;
      done      <= 1'b0;
      violation <= 1'b0;
      tlb_fault <= 1'b0;
    end else begin
      done      <= 1'b0;
      violation <= 1'b0;
      tlb_fault <= 1'b0;
      if (boot_base_we && !base_lock) begin
        base_q    <= boot_base_val;
        base_lock <= 1'b1;
      end
      case (st)
        S_IDLE: if (req_valid) begin
          vpn_q <= req_vpage;
          new_q <= req_entry & KEEP;
          lvl_q <= req_level;
          st    <= S_XLATE;
        end
        S_XLATE: if (tlb_rsp_valid) begin
          if (tlb_rsp_hit) begin
            ppn_q <= tlb_rsp_ppn;
            st    <= S_RD;
          end else begin
            tlb_fault <= 1'b1;
            st        <= S_IDLE;
          end
        end
        S_RD: if (mem_ready) st <= S_RDW;
        S_RDW: if (mem_rvalid) begin
          cur_q <= mem_rdata;
          st    <= S_MATCH;
        end
        S_MATCH: if (rule_rsp_valid) begin
          if (!rule_hit) begin
            violation <= 1'b1;
            st        <= S_IDLE;
          end else if (rule_wipe) begin
            widx <= '0;
            st   <= S_WIPE;
          end else begin
            st <= S_WRM;
          end
        end
        S_WIPE: if (mem_ready) begin
          if (wipe_last) st <= S_WRM;
          else widx <= widx + 1'b1;
        end
        S_WRM: if (mem_ready) st <= S_WRT;
        S_WRT: if (tlb_wr_ready) begin
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/perm_set_seq_chk.sv
module perm_set_seq_chk #(
  parameter int PPN_W = 20,
  parameter int DATA_W = 32,
  parameter int PAGE_SHIFT = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              boot_base_we,
  input logic [63:0]       boot_base_val,
  input logic              req_valid,
  input logic              busy,
  input logic              done,
  input logic              violation,
  input logic              tlb_fault,
  input logic              tlb_req,
  input logic              tlb_rsp_valid,
  input logic              tlb_rsp_hit,
  input logic [PPN_W-1:0]  tlb_rsp_ppn,
  input logic              tlb_wr_valid,
  input logic [15:0]       tlb_wr_entry,
  input logic              rule_req,
  input logic              rule_rsp_valid,
  input logic              rule_hit,
  input logic              rule_wipe,
  input logic              mem_valid,
  input logic              mem_we,
  input logic              mem_wide,
  input logic [63:0]       mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ready
);
  localparam int WIPE_N = (1 << PAGE_SHIFT) / (DATA_W / 8);

  logic [63:0]      cb;
  logic             cbl;
  logic [PPN_W-1:0] cppn;
  logic             rmiss;
  logic             wneed;
  logic [31:0]      wcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cb <= '0; cbl <= 1'b0; cppn <= '0; rmiss <= 1'b0; wneed <= 1'b0; wcnt <= '0;
    end else begin
      if (boot_base_we && !cbl) begin cb <= boot_base_val; cbl <= 1'b1; end
      if (tlb_req && tlb_rsp_valid && tlb_rsp_hit) cppn <= tlb_rsp_ppn;
      if (req_valid && !busy) begin rmiss <= 1'b0; wneed <= 1'b0; wcnt <= '0; end
      if (rule_req && rule_rsp_valid) begin
        rmiss <= !rule_hit;
        wneed <= rule_hit && rule_wipe;
      end
      if (mem_valid && mem_we && mem_wide && mem_ready) wcnt <= wcnt + 1;
    end
  end

  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);
  p_flags_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done || violation || tlb_fault) |-> (!busy && $onehot0({done, violation, tlb_fault})));
  p_fault_on_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_req && tlb_rsp_valid && !tlb_rsp_hit) |=> tlb_fault);
  p_read_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_we) |-> (mem_addr == cb + (64'(cppn) << 1)));
  p_violation_on_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rule_req && rule_rsp_valid && !rule_hit) |=> violation);
  p_no_write_after_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rmiss |-> !((mem_valid && mem_we) || tlb_wr_valid));
  p_wipe_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_wide) |-> (mem_wdata == '0));
  p_wipe_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we && !mem_wide) |-> (!wneed || wcnt == 32'(WIPE_N)));
  p_reserved_mem_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we && !mem_wide) |-> ((mem_wdata >> 11) == '0));
  p_reserved_tlb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_wr_valid |-> (tlb_wr_entry[15:11] == 5'd0));
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));
endmodule

bind perm_set_seq perm_set_seq_chk #(.PPN_W(PPN_W), .DATA_W(DATA_W), .PAGE_SHIFT(PAGE_SHIFT)) u_chk (
  .clk(clk), .rst_n(rst_n), .boot_base_we(boot_base_we), .boot_base_val(boot_base_val),
  .req_valid(req_valid), .busy(busy), .done(done), .violation(violation), .tlb_fault(tlb_fault),
  .tlb_req(tlb_req), .tlb_rsp_valid(tlb_rsp_valid), .tlb_rsp_hit(tlb_rsp_hit), .tlb_rsp_ppn(tlb_rsp_ppn),
  .tlb_wr_valid(tlb_wr_valid), .tlb_wr_entry(tlb_wr_entry), .rule_req(rule_req),
  .rule_rsp_valid(rule_rsp_valid), .rule_hit(rule_hit), .rule_wipe(rule_wipe),
  .mem_valid(mem_valid), .mem_we(mem_we), .mem_wide(mem_wide), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ready(mem_ready)
);

// File: tb/perm_set_seq_bench.sv
module perm_set_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int VPN_W = 20;
  localparam int PPN_W = 20;
  localparam int DATA_W = 32;
  localparam int PAGE_SHIFT = 12;
  localparam int BYTES = DATA_W / 8;
  localparam int WIPE_N = (1 << PAGE_SHIFT) / BYTES;
  localparam logic [63:0] BASE1 = 64'h0000_0001_2000_0000;
  localparam logic [63:0] BASE2 = 64'h0000_0000_0040_0000;

  logic clk = 0, rst_n = 0;
  logic boot_base_we = 0;
  logic [63:0] boot_base_val = '0;
  logic req_valid = 0;
  logic [VPN_W-1:0] req_vpage = '0;
  logic [15:0] req_entry = '0;
  logic [1:0] req_level = '0;
  logic busy, done, violation, tlb_fault, tlb_req, tlb_wr_valid, rule_req;
  logic mem_valid, mem_we, mem_wide;
  logic [VPN_W-1:0] tlb_vpage, tlb_wr_vpage;
  logic [15:0] tlb_wr_entry, rule_cur, rule_new;
  logic [1:0] rule_level;
  logic [63:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic tlb_rsp_valid = 0, tlb_rsp_hit = 0, tlb_wr_ready = 0;
  logic [PPN_W-1:0] tlb_rsp_ppn = '0;
  logic rule_rsp_valid = 0, rule_hit = 0, rule_wipe = 0;
  logic mem_ready = 0, mem_rvalid = 0;
  logic [15:0] mem_rdata = '0;

  perm_set_seq #(.VPN_W(VPN_W), .PPN_W(PPN_W), .DATA_W(DATA_W), .PAGE_SHIFT(PAGE_SHIFT)) u_perm_set_seq (
    .clk(clk), .rst_n(rst_n), .boot_base_we(boot_base_we), .boot_base_val(boot_base_val),
    .req_valid(req_valid), .req_vpage(req_vpage), .req_entry(req_entry), .req_level(req_level),
    .busy(busy), .done(done), .violation(violation), .tlb_fault(tlb_fault),
    .tlb_req(tlb_req), .tlb_vpage(tlb_vpage), .tlb_rsp_valid(tlb_rsp_valid), .tlb_rsp_hit(tlb_rsp_hit),
    .tlb_rsp_ppn(tlb_rsp_ppn), .tlb_wr_valid(tlb_wr_valid), .tlb_wr_vpage(tlb_wr_vpage),
    .tlb_wr_entry(tlb_wr_entry), .tlb_wr_ready(tlb_wr_ready), .rule_req(rule_req),
    .rule_level(rule_level), .rule_cur(rule_cur), .rule_new(rule_new), .rule_rsp_valid(rule_rsp_valid),
    .rule_hit(rule_hit), .rule_wipe(rule_wipe), .mem_valid(mem_valid), .mem_we(mem_we),
    .mem_wide(mem_wide), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // responder models, all acting on the falling edge
  logic [15:0] perm_tab [0:63];
  bit cfg_hit, cfg_wipe, stall_en, stall_ph, rd_pend;
  int rd_idx, n_look, n_rd, n_rule, n_wipe, wipe_bad, n_ent, n_tlbwr, wipes_at_ent;
  logic [63:0] rd_addr_log, ent_addr_log;
  logic [15:0] ent_data_log, rule_cur_log, rule_new_log, tlbwr_ent_log;
  logic [1:0] rule_lvl_log;
  logic [VPN_W-1:0] tlbwr_vpn_log;
  logic [PPN_W-1:0] cur_ppn;

  always @(negedge clk) begin
    mem_rvalid = 0;
    if (rd_pend) begin
      mem_rvalid = 1;
      mem_rdata = (rd_idx >= 0 && rd_idx < 64) ? perm_tab[rd_idx] : 16'hDEAD;
      rd_pend = 0;
    end
    tlb_rsp_valid = tlb_req;
    tlb_rsp_hit = (tlb_vpage[3:0] != 4'hF);
    tlb_rsp_ppn = PPN_W'(tlb_vpage) + PPN_W'(7);
    if (tlb_req) begin
      n_look++;
      cur_ppn = tlb_rsp_ppn;
    end
    stall_ph = stall_en ? ~stall_ph : 1'b0;
    mem_ready = mem_valid && !stall_ph;
    if (mem_valid && mem_ready) begin
      if (!mem_we) begin
        n_rd++;
        rd_addr_log = mem_addr;
        rd_idx = int'((mem_addr - BASE1) >> 1);
        rd_pend = 1;
      end else if (mem_wide) begin
        if (mem_addr != (64'(cur_ppn) << PAGE_SHIFT) + 64'(n_wipe * BYTES) || mem_wdata != '0)
          wipe_bad++;
        n_wipe++;
      end else begin
        n_ent++;
        ent_addr_log = mem_addr;
        ent_data_log = mem_wdata[15:0];
        wipes_at_ent = n_wipe;
        if (((mem_addr - BASE1) >> 1) < 64) perm_tab[int'((mem_addr - BASE1) >> 1)] = mem_wdata[15:0];
      end
    end
    rule_rsp_valid = rule_req;
    rule_hit = cfg_hit;
    rule_wipe = cfg_wipe;
    if (rule_req) begin
      n_rule++;
      rule_lvl_log = rule_level;
      rule_cur_log = rule_cur;
      rule_new_log = rule_new;
    end
    tlb_wr_ready = tlb_wr_valid;
    if (tlb_wr_valid) begin
      n_tlbwr++;
      tlbwr_vpn_log = tlb_wr_vpage;
      tlbwr_ent_log = tlb_wr_entry;
    end
  end

  task automatic tick();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic run_req(input logic [VPN_W-1:0] vp, input logic [15:0] ent, input logic [1:0] lvl,
                         input bit hit, input bit wipe, input bit stall, input bit inject);
    bit tlb_ok;
    int k;
    logic [PPN_W-1:0] ppn;
    logic [15:0] old_ent, new_ent;
    tlb_ok = (vp[3:0] != 4'hF);
    ppn = PPN_W'(vp) + PPN_W'(7);
    old_ent = tlb_ok ? perm_tab[int'(ppn)] : 16'h0;
    new_ent = ent & 16'h07FF;
    n_look = 0; n_rd = 0; n_rule = 0; n_wipe = 0; wipe_bad = 0; n_ent = 0; n_tlbwr = 0;
    wipes_at_ent = -1;
    cfg_hit = hit; cfg_wipe = wipe; stall_en = stall;
    req_vpage = vp; req_entry = ent; req_level = lvl; req_valid = 1;
    tick();
    req_valid = 0;
    k = 1;
    chk(busy == 1, "R1 busy after accept", 64'(busy), 1);
    while (!(done || violation || tlb_fault) && k < 6000) begin
      if (inject && k == 3) begin req_vpage = vp + 1; req_valid = 1; end
      else req_valid = 0;
      tick();
      k++;
    end
    req_valid = 0;
    chk(busy == 0, "R1 busy low with outcome", 64'(busy), 0);
    if (!tlb_ok) begin
      chk(tlb_fault == 1, "R2 fault on miss", 64'(tlb_fault), 1);
      chk(n_rd == 0 && n_rule == 0 && n_ent == 0 && n_tlbwr == 0, "R2 no traffic after miss",
          64'(n_rd + n_rule + n_ent + n_tlbwr), 0);
      if (!stall) chk(k - 1 == 1, "R10 fault latency", 64'(k - 1), 1);
    end else begin
      chk(rd_addr_log == BASE1 + (64'(ppn) << 1), "R3 entry read address", rd_addr_log, BASE1 + (64'(ppn) << 1));
      chk(rule_lvl_log == lvl && rule_cur_log == old_ent, "R5 rule level and current entry",
          {46'h0, rule_lvl_log, rule_cur_log}, {46'h0, lvl, old_ent});
      chk(rule_new_log == new_ent, "R9 reserved bits cleared on query", 64'(rule_new_log), 64'(new_ent));
      if (!hit) begin
        chk(violation == 1, "R6 violation pulse", 64'(violation), 1);
        chk(n_ent == 0 && n_tlbwr == 0 && n_wipe == 0 && perm_tab[int'(ppn)] == old_ent,
            "R6 nothing written", 64'(n_ent + n_tlbwr + n_wipe), 0);
        if (!stall) chk(k - 1 == 4, "R10 violation latency", 64'(k - 1), 4);
      end else begin
        chk(done == 1, "R8 done pulse", 64'(done), 1);
        chk(n_wipe == (wipe ? WIPE_N : 0) && wipe_bad == 0, "R7 wipe words and addresses",
            64'(n_wipe), 64'(wipe ? WIPE_N : 0));
        chk(wipes_at_ent == (wipe ? WIPE_N : 0), "R7 wipe before entry write",
            64'(wipes_at_ent), 64'(wipe ? WIPE_N : 0));
        chk(n_ent == 1 && ent_addr_log == BASE1 + (64'(ppn) << 1) && ent_data_log == new_ent,
            "R8 entry write", {32'(n_ent), 16'h0, ent_data_log}, {32'd1, 16'h0, new_ent});
        chk(n_tlbwr == 1 && tlbwr_vpn_log == vp && tlbwr_ent_log == new_ent, "R8 TLB update",
            64'(tlbwr_ent_log), 64'(new_ent));
        if (!stall) chk(k - 1 == 6 + (wipe ? WIPE_N : 0), "R10 done latency", 64'(k - 1),
                        64'(6 + (wipe ? WIPE_N : 0)));
      end
    end
    if (inject) begin
      repeat (4) tick();
      chk(n_look == 1 && busy == 0, "R1 request while busy ignored", 64'(n_look), 1);
    end
    tick();
  endtask

  initial begin
    for (int i = 0; i < 64; i++) perm_tab[i] = 16'(i * 16'h0123) & 16'h07FF;
    stall_ph = 0; rd_pend = 0;
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk(busy == 0 && done == 0 && violation == 0 && tlb_fault == 0, "R1 reset flags", 64'({busy, done, violation, tlb_fault}), 0);
    chk(mem_valid == 0 && tlb_req == 0 && rule_req == 0 && tlb_wr_valid == 0, "R1 reset requests",
        64'({mem_valid, tlb_req, rule_req, tlb_wr_valid}), 0);
    boot_base_we = 1; boot_base_val = BASE1;
    tick();
    boot_base_val = BASE2;
    tick();
    boot_base_we = 0;
    tick();
    // R4: the second load must be ignored, visible through the read address checks below
    for (int v = 0; v < 12; v++)
      run_req(VPN_W'(v * 3 + 1), 16'hFFFF ^ 16'(v * 16'h0931), 2'(v % 3),
              (v % 4) != 3, (v % 4) == 1, v % 2, 0);
    run_req(VPN_W'(15), 16'h0155, 2'd1, 1, 0, 0, 0);
    run_req(VPN_W'(40), 16'hF9C3, 2'd2, 1, 0, 1, 1);
    run_req(VPN_W'(41), 16'h0000, 2'd0, 1, 1, 0, 0);
    chk(perm_tab[int'(VPN_W'(41) + 7)] == 16'h0000, "R4 base kept after second load",
        64'(perm_tab[48]), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule